// File: doc/BRIEF.md
# Register-Selected DDS Phase Core

This core is a direct digital synthesiser that runs on a single master clock. Two 32-bit tuning words and four 12-bit phase offset words are held outside the core and presented on its inputs. A one-bit frequency select pin picks the tuning word that the phase accumulator adds on every clock. A two-bit phase select pin picks the offset that is added to the top of the accumulator. The summed phase addresses a quarter-wave sine table, and the core emits an unsigned 10-bit offset-binary code for an external DAC.

Both select pins are sampled on the rising clock edge. Frequency-shift and phase-shift keying therefore come from toggling pins, with no register rewrite. The output is a free-running stream with one new code on each active clock. It has no valid/ready handshake because no back-pressure is possible: a DAC takes every sample. The sleep input freezes the whole pipeline and the reset input returns it to midscale.

Top module: `dds_phase_core`

## Requirements
- R1: While `rst_n` is low the accumulator, the phase stage and the output are cleared, and `sample` reads 512. The first sample after release also reads 512.
- R2: On each active edge the accumulator grows by the selected 32-bit tuning word, modulo 2^32. The output frequency is tuning_word / 2^32 times the clock frequency.
- R3: `fsel` is sampled on the rising edge. At an edge where it is 0 the accumulator adds `tune_a`, and where it is 1 it adds `tune_b`.
- R4: At each active edge the 12-bit offset chosen by `psel` is added, modulo 2^12, to accumulator bits [31:20] and registered as the phase. `psel` codes 0, 1, 2 and 3 select `ofs_0`, `ofs_1`, `ofs_2` and `ofs_3`.
- R5: The sample code is 512 + round(511·sin(2π·i/256)), where i is bits [11:4] of the registered phase. The result is in the range 1..1023, with i=0 giving 512, i=64 giving 1023, i=128 giving 512 and i=192 giving 1.
- R6: A phase registered at one active edge appears on `sample` at the next active edge. The accumulator therefore reaches the output two active clocks later.
- R7: While `sleep_n` is low, no register changes and `sample` holds, whatever the select and word inputs do. When `sleep_n` returns high, the sequence resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_n | input | 1 | Clock enable for the whole pipeline; low freezes it |
| fsel | input | 1 | Tuning word select, sampled on the rising edge |
| psel | input | 2 | Phase offset select, sampled on the rising edge |
| tune_a | input | 32 | Tuning word used when fsel is 0 |
| tune_b | input | 32 | Tuning word used when fsel is 1 |
| ofs_0 | input | 12 | Phase offset for psel 0 |
| ofs_1 | input | 12 | Phase offset for psel 1 |
| ofs_2 | input | 12 | Phase offset for psel 2 |
| ofs_3 | input | 12 | Phase offset for psel 3 |
| sample | output | 10 | Offset-binary sine code for the DAC |

## Verification
A corrupted phase register shows as a wrong code on the very next active edge. A wrong accumulator value shows two edges later. An accumulator fault does not heal: every later code carries the same phase error, so a stream compared on every clock catches it at once. Select-sampling faults are exposed by toggling `fsel` and `psel` every few cycles. Table faults are exposed by sweeping all 256 table indices with a unit step. Sleep faults are exposed by changing every input while the core is frozen and then comparing the resumed stream.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Quarter-wave amplitude: round(511 * sin(pi/2 * k/64)), k = 0..63
  function automatic logic [8:0] qtr_amp(input logic [5:0] k);
    logic [8:0] a;
    case (k)
      6'd0:  a = 9'd0;   6'd1:  a = 9'd13;  6'd2:  a = 9'd25;  6'd3:  a = 9'd38;
      6'd4:  a = 9'd50;  6'd5:  a = 9'd63;  6'd6:  a = 9'd75;  6'd7:  a = 9'd87;
      6'd8:  a = 9'd100; 6'd9:  a = 9'd112; 6'd10: a = 9'd124; 6'd11: a = 9'd136;
      6'd12: a = 9'd148; 6'd13: a = 9'd160; 6'd14: a = 9'd172; 6'd15: a = 9'd184;
      6'd16: a = 9'd196; 6'd17: a = 9'd207; 6'd18: a = 9'd218; 6'd19: a = 9'd230;
      6'd20: a = 9'd241; 6'd21: a = 9'd252; 6'd22: a = 9'd263; 6'd23: a = 9'd273;
      6'd24: a = 9'd284; 6'd25: a = 9'd294; 6'd26: a = 9'd304; 6'd27: a = 9'd314;
      6'd28: a = 9'd324; 6'd29: a = 9'd334; 6'd30: a = 9'd343; 6'd31: a = 9'd352;
      6'd32: a = 9'd361; 6'd33: a = 9'd370; 6'd34: a = 9'd379; 6'd35: a = 9'd387;
      6'd36: a = 9'd395; 6'd37: a = 9'd403; 6'd38: a = 9'd410; 6'd39: a = 9'd418;
      6'd40: a = 9'd425; 6'd41: a = 9'd432; 6'd42: a = 9'd438; 6'd43: a = 9'd445;
      6'd44: a = 9'd451; 6'd45: a = 9'd456; 6'd46: a = 9'd462; 6'd47: a = 9'd467;
      6'd48: a = 9'd472; 6'd49: a = 9'd477; 6'd50: a = 9'd481; 6'd51: a = 9'd485;
      6'd52: a = 9'd489; 6'd53: a = 9'd492; 6'd54: a = 9'd496; 6'd55: a = 9'd499;
      6'd56: a = 9'd501; 6'd57: a = 9'd503; 6'd58: a = 9'd505; 6'd59: a = 9'd507;
      6'd60: a = 9'd509; 6'd61: a = 9'd510; 6'd62: a = 9'd510; 6'd63: a = 9'd511;
      default: a = 9'd0;
    endcase
    return a;
  endfunction

  localparam logic [8:0] PEAK_AMP = 9'd511;

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel,
  input  logic [ACC_W-1:0] word_a,
  input  logic [ACC_W-1:0] word_b,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] step;

  always_comb step = sel ? word_b : word_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (en)  acc <= acc + step;
  end

  // R2 / R3: accumulator advances by the word picked at that edge
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc == ($past(acc) + ($past(sel) ? $past(word_b) : $past(word_a))));

  // R7: frozen while disabled
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc));

endmodule

// File: rtl/dds_phase_offset.sv
module dds_phase_offset #(
  parameter int PH_W  = 12,
  parameter int N_OFS = 4,
  localparam int SEL_W = $clog2(N_OFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] psel,
  input  logic [PH_W-1:0]  ofs_0,
  input  logic [PH_W-1:0]  ofs_1,
  input  logic [PH_W-1:0]  ofs_2,
  input  logic [PH_W-1:0]  ofs_3,
  input  logic [PH_W-1:0]  acc_top,
  output logic [PH_W-1:0]  phase
);

  logic [PH_W-1:0] ofs_bank [N_OFS];
  logic [PH_W-1:0] ofs_pick;

  always_comb begin
    ofs_bank[0] = ofs_0;
    ofs_bank[1] = ofs_1;
    ofs_bank[2] = ofs_2;
    ofs_bank[3] = ofs_3;
    ofs_pick    = ofs_bank[psel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (en)  phase <= acc_top + ofs_pick;
  end

  // R4: registered phase is accumulator top plus the chosen offset
  assert_phase_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && psel == 2'd0) |=> phase == PH_W'($past(acc_top) + $past(ofs_0)));

  assert_phase_sum3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && psel == 2'd3) |=> phase == PH_W'($past(acc_top) + $past(ofs_3)));

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int PH_W   = 12,
  parameter int LUT_AW = 8,
  parameter int SMP_W  = 10,
  localparam int QK_W  = LUT_AW - 2,
  localparam int AMP_W = SMP_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PH_W-1:0]  phase,
  output logic [SMP_W-1:0] sample
);
  import dds_pkg::*;

  localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

  logic [LUT_AW-1:0] idx;
  logic [1:0]        quad;
  logic [QK_W-1:0]   k;
  logic [QK_W-1:0]   k_addr;
  logic              at_peak;
  logic [AMP_W-1:0]  amp;
  logic [SMP_W-1:0]  code;

  always_comb begin
    idx     = phase[PH_W-1 -: LUT_AW];
    quad    = idx[LUT_AW-1 -: 2];
    k       = idx[QK_W-1:0];
    k_addr  = quad[0] ? QK_W'(~k + 1'b1) : k;   // mirrored half counts down
    at_peak = quad[0] && (k == '0);
    amp     = at_peak ? PEAK_AMP : qtr_amp(k_addr);
    code    = quad[1] ? (MID - SMP_W'(amp)) : (MID + SMP_W'(amp));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sample <= MID;
    else if (en)  sample <= code;
  end

  // R5: offset-binary code never reaches zero
  assert_code_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample != '0);

  // R5 / R6: phase index zero yields midscale one edge later
  assert_zero_phase_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx == '0) |=> sample == MID);

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter int LUT_AW = 8,
  parameter int SMP_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_n,
  input  logic             fsel,
  input  logic [1:0]       psel,
  input  logic [ACC_W-1:0] tune_a,
  input  logic [ACC_W-1:0] tune_b,
  input  logic [PH_W-1:0]  ofs_0,
  input  logic [PH_W-1:0]  ofs_1,
  input  logic [PH_W-1:0]  ofs_2,
  input  logic [PH_W-1:0]  ofs_3,
  output logic [SMP_W-1:0] sample
);

  localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  phase;
  logic             en;

  always_comb en = sleep_n;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(fsel),
    .word_a(tune_a), .word_b(tune_b), .acc(acc)
  );

  dds_phase_offset #(.PH_W(PH_W), .N_OFS(4)) u_ofs (
    .clk(clk), .rst_n(rst_n), .en(en), .psel(psel),
    .ofs_0(ofs_0), .ofs_1(ofs_1), .ofs_2(ofs_2), .ofs_3(ofs_3),
    .acc_top(acc[ACC_W-1 -: PH_W]), .phase(phase)
  );

  dds_sine_lut #(.PH_W(PH_W), .LUT_AW(LUT_AW), .SMP_W(SMP_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .sample(sample)
  );

  // R1: first edge after reset release still shows midscale
  assert_mid_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> sample == MID);

  // R7: output frozen across a sleeping edge
  assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sleep_n) |-> $stable(sample));

endmodule

// File: tb/test_dds_phase_core.sv
`timescale 1ns/1ps
module test_dds_phase_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_n = 1'b1;
  logic        fsel = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [31:0] tune_a = '0, tune_b = '0;
  logic [11:0] ofs_0 = '0, ofs_1 = '0, ofs_2 = '0, ofs_3 = '0;
  logic [9:0]  sample;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dds_phase_core i_dds_phase_core (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fsel(fsel), .psel(psel),
    .tune_a(tune_a), .tune_b(tune_b),
    .ofs_0(ofs_0), .ofs_1(ofs_1), .ofs_2(ofs_2), .ofs_3(ofs_3),
    .sample(sample)
  );

  // ---------------- behavioural reference ----------------
  longint unsigned m_acc = 0;
  int m_ph  = 0;
  int m_smp = 512;

  function automatic int ref_code(int i);
    real a, v;
    int  r;
    a = 2.0 * 3.14159265358979 * i / 256.0;
    v = 511.0 * $sin(a);
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    return 512 + r;
  endfunction

  function automatic int pick_ofs(int s);
    case (s)
      0: return int'(ofs_0);
      1: return int'(ofs_1);
      2: return int'(ofs_2);
      default: return int'(ofs_3);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_ph = 0; m_smp = 512;
    end else if (sleep_n) begin
      m_smp = ref_code(m_ph >> 4);
      m_ph  = (int'(m_acc >> 20) + pick_ofs(int'(psel))) & 12'hFFF;
      m_acc = (m_acc + (fsel ? tune_b : tune_a)) & 64'hFFFF_FFFF;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(int act, int exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sample=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(int n, string tag);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk(int'(sample), m_smp, tag);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    int held;
    // R1: reset state
    run(3, "R1");
    chk(int'(sample), 512, "R1 reset midscale");

    // R6: latency with offset at index 64 and zero tuning word
    ofs_0 = 12'h400;
    @(negedge clk); rst_n = 1'b1;
    run(1, "R6");
    chk(int'(sample), 512, "R6 first edge still midscale");
    run(1, "R6");
    chk(int'(sample), 1023, "R6 peak after two edges");

    // R5: unit step sweeps all 256 table indices, including 128 and 192
    ofs_0 = 12'h000; tune_a = 32'h0100_0000;
    run(300, "R5 sweep");
    ofs_0 = 12'hC00; tune_a = 32'h0;
    run(3, "R5");
    chk(int'(sample), ref_code(int'((m_acc >> 24) & 255) + 192), "R5 trough index");

    // R3: frequency shift keying by toggling fsel
    tune_a = 32'h0137_5000; tune_b = 32'h0A00_0123; ofs_0 = 12'h0;
    for (int t = 0; t < 20; t++) begin
      fsel = t[0];
      run(7, "R3 fsk");
    end

    // R4: phase shift keying through all four offsets
    ofs_0 = 12'h000; ofs_1 = 12'h400; ofs_2 = 12'h800; ofs_3 = 12'hC37;
    tune_a = 32'h0040_0000; fsel = 1'b0;
    for (int t = 0; t < 24; t++) begin
      psel = 2'(t % 4);
      run(5, "R4 psk");
    end
    ofs_1 = 12'hFFF; ofs_2 = 12'h123;
    for (int t = 0; t < 16; t++) begin
      psel = 2'((t * 3) % 4);
      run(3, "R4 psk odd");
    end

    // R2: wrap modulo 2^32 with large words
    psel = 2'd0; tune_a = 32'hFFFF_FFFF; tune_b = 32'h8000_0001;
    run(40, "R2 wrap down");
    fsel = 1'b1;
    run(40, "R2 wrap half");
    tune_b = 32'hF123_4567;
    run(60, "R2 wrap big");

    // R7: sleep freezes output while every input moves
    fsel = 1'b0; tune_a = 32'h0333_3333;
    run(5, "R7 pre");
    held = int'(sample);
    sleep_n = 1'b0;
    for (int t = 0; t < 20; t++) begin
      fsel = t[0]; psel = 2'(t % 4); tune_a = tune_a + 32'h1111;
      run(1, "R7 asleep");
      chk(int'(sample), held, "R7 held value");
    end
    sleep_n = 1'b1; fsel = 1'b0; psel = 2'd1;
    run(30, "R7 resume");

    // R1: reset asserted mid-run
    @(negedge clk); rst_n = 1'b0;
    run(2, "R1 mid-run");
    chk(int'(sample), 512, "R1 mid-run midscale");
    ofs_1 = 12'h0;
    rst_n = 1'b1;
    run(1, "R1 release");
    chk(int'(sample), 512, "R1 first after release");
    run(20, "R1 after");

    done = 1;
    summary();
  end

endmodule